// File: doc/BRIEF.md
# Maskable Interrupt Controller with Fast-Request Steering

This block gathers a set of level-sensitive interrupt source lines and turns them into two processor request outputs: a normal request and a fast request. Each source passes through an enable bit in a mask register. A steering register then sends every enabled, active source to exactly one of the two request outputs. Software sees the raw source lines, the sources pending on the normal path and the sources pending on the fast path through three read-only words.

Sources are level-sensitive. The controller holds no latch and needs no acknowledge: a request disappears once the peripheral releases its line. A separate wake output tells the power manager when an idle state may end. A strict-wake control bit picks the rule for it: either only enabled sources may wake the core, or any active source may, masked ones included. All three outputs are registered, so each one reflects the inputs and the register contents seen at the previous rising clock edge.

The register bus is a word-addressed write port with a combinational read port. Word offsets are 0 for raw sources (read only), 1 for the mask, 2 for steering, 3 for normal pending (read only), 4 for fast pending (read only) and 5 for control. Control bit 0 is the strict-wake bit. Offsets 6 and 7 are unused.

Top module: `irq_steer_ctrl`

## Requirements
- R1: The mask register (offset 1) is written and read back in full; a mask bit of 1 enables its source and 0 blocks it from both pending words and both requests.
- R2: The steering register (offset 2) is written and read back in full; a steering bit of 0 routes its source to the normal path and 1 routes it to the fast path.
- R3: Offset 3 reads source AND mask AND NOT steering, and offset 4 reads source AND mask AND steering, both in the same cycle as the inputs.
- R4: irq_norm_o is high in a cycle exactly when, at the preceding rising edge, at least one normal pending bit was set.
- R5: irq_fast_o is high in a cycle exactly when, at the preceding rising edge, at least one fast pending bit was set.
- R6: With control bit 0 set, wake_o is high one edge after any source is active and enabled, and is otherwise low.
- R7: With control bit 0 clear, wake_o is high one edge after any source is active, whatever the mask holds.
- R8: Requests are level-sensitive: when a source line drops, its pending bits clear at once and its request output falls at the next edge, with no acknowledge.
- R9: Reset clears mask, steering and control to zero and drives all three outputs low.
- R10: Writes to offsets 0, 3, 4, 6 and 7 change no state; offsets 6 and 7 read zero, and control bits above bit 0 read zero.
- R11: Offset 0 reads the current source lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level-sensitive source lines, active high |
| bus_addr_i | input | 3 | Word offset for read and write |
| bus_we_i | input | 1 | Write strobe, takes effect at the rising edge |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Combinational read data for bus_addr_i |
| irq_norm_o | output | 1 | Registered normal request |
| irq_fast_o | output | 1 | Registered fast request |
| wake_o | output | 1 | Registered idle-wake qualification |

## Verification
The assertions assume the source lines and bus inputs are synchronous to the clock and settled before each rising edge. Under that assumption, each output is a one-edge-delayed function of the sampled sources and registers. The stimulus meets this by changing inputs only just after the falling edge. It mixes directed steering and mask patterns, toggles of the strict-wake bit with masked-only activity, and random source and register traffic. This includes writes aimed at read-only and unused offsets, so that every rule is exercised while the inputs stay clean.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_STRICT_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    OFS_RAW   = 3'd0,
    OFS_MASK  = 3'd1,
    OFS_STEER = 3'd2,
    OFS_NPEND = 3'd3,
    OFS_FPEND = 3'd4,
    OFS_CTRL  = 3'd5
  } reg_ofs_e;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  norm_pend_i,
  input  logic [N_SRC-1:0]  fast_pend_i,
  output logic [N_SRC-1:0]  mask_q_o,
  output logic [N_SRC-1:0]  steer_q_o,
  output logic              strict_q_o,
  output logic [N_SRC-1:0]  rdata_o
);
  // Write decode, one strobe per writable word.
  logic wr_mask, wr_steer, wr_ctrl;
  assign wr_mask  = we_i && (addr_i == OFS_MASK);
  assign wr_steer = we_i && (addr_i == OFS_STEER);
  assign wr_ctrl  = we_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o   <= '0;
      steer_q_o  <= '0;
      strict_q_o <= 1'b0;
    end else begin
      if (wr_mask)  mask_q_o   <= wdata_i;
      if (wr_steer) steer_q_o  <= wdata_i;
      if (wr_ctrl)  strict_q_o <= wdata_i[CTRL_STRICT_BIT];
    end
  end

  // Combinational read mux.
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_RAW:   rdata_o = src_i;
      OFS_MASK:  rdata_o = mask_q_o;
      OFS_STEER: rdata_o = steer_q_o;
      OFS_NPEND: rdata_o = norm_pend_i;
      OFS_FPEND: rdata_o = fast_pend_i;
      OFS_CTRL:  rdata_o[CTRL_STRICT_BIT] = strict_q_o;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] steer_i,
  input  logic             strict_i,
  output logic [N_SRC-1:0] norm_pend_o,
  output logic [N_SRC-1:0] fast_pend_o,
  output logic             wake_cond_o,
  output logic             irq_norm_q_o,
  output logic             irq_fast_q_o,
  output logic             wake_q_o
);
  function automatic logic [N_SRC-1:0] pend_normal(
    input logic [N_SRC-1:0] s, input logic [N_SRC-1:0] m, input logic [N_SRC-1:0] l);
    return s & m & ~l;
  endfunction

  function automatic logic [N_SRC-1:0] pend_fast(
    input logic [N_SRC-1:0] s, input logic [N_SRC-1:0] m, input logic [N_SRC-1:0] l);
    return s & m & l;
  endfunction

  function automatic logic may_wake(
    input logic [N_SRC-1:0] s, input logic [N_SRC-1:0] m, input logic strict);
    return strict ? |(s & m) : |s;
  endfunction

  assign norm_pend_o = pend_normal(src_i, mask_i, steer_i);
  assign fast_pend_o = pend_fast(src_i, mask_i, steer_i);
  assign wake_cond_o = may_wake(src_i, mask_i, strict_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_norm_q_o <= 1'b0;
      irq_fast_q_o <= 1'b0;
      wake_q_o     <= 1'b0;
    end else begin
      irq_norm_q_o <= |norm_pend_o;
      irq_fast_q_o <= |fast_pend_o;
      wake_q_o     <= wake_cond_o;
    end
  end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic              irq_norm_o,
  output logic              irq_fast_o,
  output logic              wake_o
);
  // Named internal wires, also observed by the bound checker.
  logic [N_SRC-1:0] mask_q, steer_q, norm_pend, fast_pend;
  logic             strict_q, wake_cond;

  irq_steer_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .wdata_i     (bus_wdata_i),
    .src_i       (src_i),
    .norm_pend_i (norm_pend),
    .fast_pend_i (fast_pend),
    .mask_q_o    (mask_q),
    .steer_q_o   (steer_q),
    .strict_q_o  (strict_q),
    .rdata_o     (bus_rdata_o)
  );

  irq_steer_route #(.N_SRC(N_SRC)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_i        (src_i),
    .mask_i       (mask_q),
    .steer_i      (steer_q),
    .strict_i     (strict_q),
    .norm_pend_o  (norm_pend),
    .fast_pend_o  (fast_pend),
    .wake_cond_o  (wake_cond),
    .irq_norm_q_o (irq_norm_o),
    .irq_fast_q_o (irq_fast_o),
    .wake_q_o     (wake_o)
  );
endmodule

// File: rtl/irq_steer_ctrl_chk.sv
module irq_steer_ctrl_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] norm_pend,
  input logic [N_SRC-1:0] fast_pend,
  input logic             strict_q,
  input logic             irq_norm_o,
  input logic             irq_fast_o,
  input logic             wake_o
);
  assert_masked_never_pends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((norm_pend | fast_pend) & ~mask_q) == '0);

  assert_paths_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_pend & fast_pend) == '0);

  assert_norm_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|norm_pend) |=> irq_norm_o);

  assert_norm_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|norm_pend) |=> !irq_norm_o);

  assert_fast_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fast_pend) |=> irq_fast_o);

  assert_fast_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fast_pend) |=> !irq_fast_o);

  assert_strict_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strict_q && !(|(src_i & mask_q))) |=> !wake_o);

  assert_loose_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strict_q && (|src_i)) |=> wake_o);

  assert_drop_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (!irq_norm_o && !irq_fast_o && !wake_o));
endmodule

bind irq_steer_ctrl irq_steer_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .mask_q     (mask_q),
  .norm_pend  (norm_pend),
  .fast_pend  (fast_pend),
  .strict_q   (strict_q),
  .irq_norm_o (irq_norm_o),
  .irq_fast_o (irq_fast_o),
  .wake_o     (wake_o)
);

// File: tb/irq_steer_ctrl_tb_top.sv
module irq_steer_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [2:0]    addr = '0;
  logic          we = 1'b0;
  logic [NS-1:0] wdata = '0;
  logic [NS-1:0] rdata;
  logic          irq_norm, irq_fast, wake;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer_ctrl #(.N_SRC(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_norm_o(irq_norm), .irq_fast_o(irq_fast), .wake_o(wake)
  );

  // Behavioural reference state.
  logic [NS-1:0] m_mask = '0, m_steer = '0;
  bit m_strict = 0;
  bit e_norm = 0, e_fast = 0, e_wake = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_steer = '0; m_strict = 0;
      e_norm = 0; e_fast = 0; e_wake = 0;
    end else begin
      e_norm = 0; e_fast = 0; e_wake = 0;
      for (int i = 0; i < NS; i++) begin
        if (src[i] && m_mask[i] && !m_steer[i]) e_norm = 1;
        if (src[i] && m_mask[i] && m_steer[i])  e_fast = 1;
        if (src[i] && (m_mask[i] || !m_strict)) e_wake = 1;
      end
      if (we) begin
        if (addr == 3'd1) m_mask = wdata;
        else if (addr == 3'd2) m_steer = wdata;
        else if (addr == 3'd5) m_strict = wdata[0];
      end
    end
  end

  function automatic logic [NS-1:0] model_read(input logic [2:0] a);
    logic [NS-1:0] r;
    r = '0;
    for (int i = 0; i < NS; i++) begin
      case (a)
        3'd0: r[i] = src[i];
        3'd1: r[i] = m_mask[i];
        3'd2: r[i] = m_steer[i];
        3'd3: r[i] = src[i] & m_mask[i] & ~m_steer[i];
        3'd4: r[i] = src[i] & m_mask[i] & m_steer[i];
        default: r[i] = 1'b0;
      endcase
    end
    if (a == 3'd5) r[0] = m_strict;
    return r;
  endfunction

  function automatic string read_req(input logic [2:0] a);
    case (a)
      3'd0: return "R11";
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 irq_norm", {31'b0, irq_norm}, {31'b0, e_norm});
      check("R5 irq_fast", {31'b0, irq_fast}, {31'b0, e_fast});
      check(m_strict ? "R6 wake" : "R7 wake", {31'b0, wake}, {31'b0, e_wake});
      check(read_req(addr), rdata, model_read(addr));
    end
  end

  task automatic drive(input logic [2:0] a, input bit w, input logic [NS-1:0] d, input logic [NS-1:0] s);
    @(negedge clk); #1;
    addr = a; we = w; wdata = d; src = s;
  endtask

  task automatic idle(input logic [2:0] a, input logic [NS-1:0] s);
    drive(a, 0, '0, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state seen through the ports.
    @(negedge clk); #2;
    check("R9 outputs", {29'b0, irq_norm, irq_fast, wake}, '0);
    addr = 3'd1; #1; check("R9 mask", rdata, '0);
    addr = 3'd2; #1; check("R9 steer", rdata, '0);
    addr = 3'd5; #1; check("R9 ctrl", rdata, '0);

    // R1: masked sources give nothing; R7 loose wake still fires.
    idle(3'd3, 32'h0000_0F00);
    idle(3'd3, 32'h0000_0F00);
    // R1, R2: enable and steer a mix.
    drive(3'd1, 1, 32'h0000_FF0F, 32'h0000_0F00);
    drive(3'd2, 1, 32'h0000_F000, 32'h0000_0F00);
    idle(3'd3, 32'h0000_F100);
    idle(3'd4, 32'h0000_F100);
    idle(3'd4, 32'h0000_1000);
    // R8: drop every source, no acknowledge.
    idle(3'd3, 32'h0);
    idle(3'd4, 32'h0);
    // R6: strict wake ignores masked activity.
    drive(3'd5, 1, 32'hFFFF_FFFF, 32'h0);
    idle(3'd5, 32'h0000_00F0);
    idle(3'd0, 32'h0000_00F0);
    idle(3'd0, 32'h0000_0001);
    // R10: writes to read-only and unused offsets.
    drive(3'd3, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(3'd4, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(3'd0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(3'd6, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(3'd7, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    idle(3'd1, 32'h0); idle(3'd2, 32'h0); idle(3'd6, 32'h0); idle(3'd7, 32'h0);
    drive(3'd5, 1, 32'h0000_0000, 32'h8000_0000);
    idle(3'd5, 32'h8000_0000);

    // Random traffic over every offset.
    for (int k = 0; k < 3000; k++) begin
      drive(3'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0),
            $urandom, ($urandom_range(0, 4) == 0) ? '0 : ($urandom & $urandom));
    end
    idle(3'd0, '0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule